// File: doc/BRIEF.md
# Doorbell mailbox register block

This block gives host software a small register window for posting commands to a device. The host loads a command word and, optionally, input bytes into a payload area. It then raises a doorbell bit. The block presents the command set, the opcode and the input length to an external command handler. While the request is up, the handler reads the input bytes through a private port. When the handler accepts the request, every byte of the payload area is wiped. The handler then writes its output bytes and answers with a return code, a background-started flag and an output length. The block records these in the status and command registers and drops the doorbell, which tells the host the command has finished.

The register window also carries three other registers. A capability word describes the mailbox: the payload size as a power-of-two exponent, background-interrupt support and an interrupt message number. A background-command status register reflects, on a full-width read, the opcode, progress and return code of an operation that runs in the background. Reading the status register at full width drops the background flag once that operation reports any progress. The register offsets are fixed: capability 0x00, control 0x04, command 0x08, status 0x10, background status 0x18, payload from 0x20.

Top module: `mbox_regs`

## Requirements
- R1: After reset, an 8-byte read at 0x00 returns 0x4CB: capability word {type[22:19]=0, ready time[18:11]=0, message number[10:7]=9, background-interrupt capable[6]=1, payload exponent[4:0]=11} in the low half, with the control word (doorbell in bit 0) clear in the high half. The command register (0x08) and the status register (0x10) read zero.
- R2: Write sizes are encoded 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes, with the data right-aligned on the write bus. Below 0x20, a 4-byte write changes only the capability word (0x00) or the control word (0x04). A 4-byte write to any other offset below 0x20 has no effect, and so does any 1-byte or 2-byte write there.
- R3: Below 0x20, an 8-byte write changes only the command register (0x08) and the stored background-status word (0x18). An 8-byte write to the status register (0x10) or to 0x00 has no effect.
- R4: A write of any size at offset 0x20 or above stores exactly its bytes, little-endian, into the payload area at that offset; no other byte of the payload area changes.
- R5: A control write with bit 0 set while idle raises req_valid on the next cycle. req_opcode carries command bits [7:0], req_cmd_set carries bits [15:8] and req_len carries bits [36:16]. req_valid stays up until req_ready. During that time the handler reads the input payload by 8-byte word index.
- R6: In the cycle after req_ready is taken, every payload byte reads zero, whatever the earlier contents, and exec_go is high.
- R7: On resp_valid while exec_go is high, the block updates three registers, visible from the next cycle. The status register becomes {return code in [47:32], background flag in bit 0}. The command register keeps its command set and opcode, with the output length in [36:16]. The doorbell clears. Payload bytes written by the handler during exec_go are readable by the host afterwards.
- R8: From the doorbell until completion, host writes to the command register, the control word and the payload area are ignored, and the doorbell reads 1.
- R9: An 8-byte read of 0x18 returns the live background inputs: opcode in [15:0], percent complete in [22:16], return code in [47:32].
- R10: An 8-byte read of the status register returns bit 0 clear, and clears it in the register, when the background percent complete is non-zero. With a zero percentage, or with a narrower read, bit 0 is left as it is.
- R11: Reads of 1, 2 or 4 bytes return the addressed bytes right-aligned on host_rd_data, with the upper bits zero. Read data appears in the cycle after host_rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | ADDR_W | Host write byte offset |
| host_wr_size | input | 2 | Host write size code |
| host_wr_data | input | 64 | Host write data, right-aligned |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_addr | input | ADDR_W | Host read byte offset |
| host_rd_size | input | 2 | Host read size code |
| host_rd_data | output | 64 | Registered read data |
| req_valid | output | 1 | Command request to handler |
| req_ready | input | 1 | Handler has taken the request |
| req_cmd_set | output | 8 | Command set of the request |
| req_opcode | output | 8 | Opcode of the request |
| req_len | output | 21 | Input payload length |
| exec_go | output | 1 | Handler may write output and respond |
| resp_valid | input | 1 | Handler completion |
| resp_rc | input | 16 | Return code |
| resp_bg | input | 1 | Background operation started |
| resp_len | input | 21 | Output payload length |
| hnd_rd_idx | input | PAYLOAD_EXP-3 | Handler payload read word index |
| hnd_rd_data | output | 64 | Handler payload read data |
| hnd_wr_en | input | 1 | Handler payload write |
| hnd_wr_idx | input | PAYLOAD_EXP-3 | Handler payload write word index |
| hnd_wr_strb | input | 8 | Handler payload byte enables |
| hnd_wr_data | input | 64 | Handler payload write data |
| bg_opcode | input | 16 | Live background opcode |
| bg_pct | input | 7 | Live background percent complete |
| bg_rc | input | 16 | Live background return code |

## Verification
The assertions assume a well-behaved handler. It raises req_ready only while req_valid is high. It raises resp_valid and writes the payload only while exec_go is high. They also assume that host accesses are aligned to their size and stay within one register or one payload word. The bench plays the handler itself and drives every handshake one cycle at a time, under exactly those rules. All its host accesses are naturally aligned, so the byte-lane and side-effect checks stay inside the defined behaviour.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // register offsets (byte addresses in the host window)
  localparam int OFS_CAP     = 'h00;
  localparam int OFS_CTRL    = 'h04;
  localparam int OFS_CMD     = 'h08;
  localparam int OFS_STS     = 'h10;
  localparam int OFS_BGS     = 'h18;
  localparam int OFS_PAYLOAD = 'h20;

  localparam int CMD_LEN_W = 21;

  // access size codes
  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_HALF  = 2'd1;
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_EXEC = 2'd2
  } mbox_state_e;

  // capability word: exponent, bg-irq capable, message number; ready time and type zero
  function automatic logic [31:0] cap_word(input logic [4:0] pexp, input logic [3:0] msg);
    return {9'd0, 4'd0, 8'd0, msg, 1'b1, 1'b0, pexp};
  endfunction

  function automatic logic [63:0] pack_cmd(input logic [7:0] set, input logic [7:0] op,
                                           input logic [CMD_LEN_W-1:0] len);
    return {27'd0, len, set, op};
  endfunction

  function automatic logic [63:0] pack_status(input logic [15:0] rc, input logic bg);
    return {16'd0, rc, 31'd0, bg};
  endfunction

  function automatic logic [63:0] pack_bg(input logic [15:0] op, input logic [6:0] pct,
                                          input logic [15:0] rc);
    return {16'd0, rc, 9'd0, pct, op};
  endfunction

  // byte enables of an aligned access of the given size at lane lo
  function automatic logic [7:0] lane_mask(input logic [1:0] sz, input logic [2:0] lo);
    logic [7:0] m;
    case (sz)
      SZ_BYTE: m = 8'h01;
      SZ_HALF: m = 8'h03;
      SZ_WORD: m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return m << lo;
  endfunction

  // right-aligned read extraction
  function automatic logic [63:0] narrow(input logic [63:0] w, input logic [2:0] lo,
                                         input logic [1:0] sz);
    logic [63:0] sh;
    logic [63:0] m;
    sh = w >> {lo, 3'b000};
    case (sz)
      SZ_BYTE: m = 64'h0000_0000_0000_00FF;
      SZ_HALF: m = 64'h0000_0000_0000_FFFF;
      SZ_WORD: m = 64'h0000_0000_FFFF_FFFF;
      default: m = '1;
    endcase
    return sh & m;
  endfunction

endpackage

// File: rtl/mbox_seq.sv
module mbox_seq import mbox_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic req_ready,
  input  logic resp_valid,
  output logic busy,
  output logic req_valid,
  output logic exec_go,
  output logic clr_pulse,
  output logic done_pulse
);

  mbox_state_e state_q, state_d;

  assign req_valid  = (state_q == ST_REQ);
  assign exec_go    = (state_q == ST_EXEC);
  assign busy       = (state_q != ST_IDLE);
  assign clr_pulse  = req_valid && req_ready;
  assign done_pulse = exec_go && resp_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)      state_d = ST_REQ;
      ST_REQ:  if (req_ready)  state_d = ST_EXEC;
      ST_EXEC: if (resp_valid) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R5: a request stays posted until the handler takes it
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);

  // R6: execution only ever follows the payload wipe
  p_exec_after_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_go) |-> $past(clr_pulse));

  // R7: completion returns the sequencer to idle
  p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !busy);

endmodule

// File: rtl/mbox_payload.sv
module mbox_payload #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_strb,
  input  logic [63:0]      wr_data,
  input  logic [IDX_W-1:0] rda_idx,
  output logic [63:0]      rda_data,
  input  logic [IDX_W-1:0] rdb_idx,
  output logic [63:0]      rdb_data
);

  localparam int WORDS = 1 << IDX_W;

  logic [63:0]      mem [WORDS];
  logic [WORDS-1:0] live;    // word holds data written since the last wipe
  logic [63:0]      base;
  logic [63:0]      merged;

  assign base = live[wr_idx] ? mem[wr_idx] : 64'd0;

  for (genvar b = 0; b < 8; b++) begin : g_lane
    assign merged[b*8 +: 8] = wr_strb[b] ? wr_data[b*8 +: 8] : base[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     live <= '0;
    else if (clr)   live <= '0;
    else if (wr_en) live[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wr_idx] <= merged;
  end

  assign rda_data = live[rda_idx] ? mem[rda_idx] : 64'd0;
  assign rdb_data = live[rdb_idx] ? mem[rdb_idx] : 64'd0;

  // R6: a wipe leaves no word marked as holding data
  p_wipe_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (live == '0));

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs import mbox_pkg::*; #(
  parameter int PAYLOAD_EXP = 11,
  parameter int MSI_NUM     = 9,
  parameter int ADDR_W      = PAYLOAD_EXP + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr_en,
  input  logic [ADDR_W-1:0]        host_wr_addr,
  input  logic [1:0]               host_wr_size,
  input  logic [63:0]              host_wr_data,
  input  logic                     host_rd_en,
  input  logic [ADDR_W-1:0]        host_rd_addr,
  input  logic [1:0]               host_rd_size,
  output logic [63:0]              host_rd_data,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [7:0]               req_cmd_set,
  output logic [7:0]               req_opcode,
  output logic [20:0]              req_len,
  output logic                     exec_go,
  input  logic                     resp_valid,
  input  logic [15:0]              resp_rc,
  input  logic                     resp_bg,
  input  logic [20:0]              resp_len,
  input  logic [PAYLOAD_EXP-4:0]   hnd_rd_idx,
  output logic [63:0]              hnd_rd_data,
  input  logic                     hnd_wr_en,
  input  logic [PAYLOAD_EXP-4:0]   hnd_wr_idx,
  input  logic [7:0]               hnd_wr_strb,
  input  logic [63:0]              hnd_wr_data,
  input  logic [15:0]              bg_opcode,
  input  logic [6:0]               bg_pct,
  input  logic [15:0]              bg_rc
);

  localparam int IDX_W     = PAYLOAD_EXP - 3;
  localparam int PAY_BYTES = 1 << PAYLOAD_EXP;
  localparam logic [ADDR_W-1:0] PAY_LO = ADDR_W'(OFS_PAYLOAD);
  localparam logic [ADDR_W:0]   PAY_HI = (ADDR_W + 1)'(OFS_PAYLOAD + PAY_BYTES);

  logic [31:0] cap_q, ctrl_q;
  logic [63:0] cmd_q, sts_q, bgs_q;

  // ---------------- write decode ----------------
  logic                   busy, start, clr_pulse, done;
  logic                   w_in_pay, w_reg, w32, w64;
  logic                   cap_we, ctrl_we, cmd_we, bgs_we, host_pay_we;
  logic [PAYLOAD_EXP-1:0] w_off;

  assign w_off    = PAYLOAD_EXP'(host_wr_addr - PAY_LO);
  assign w_in_pay = ({1'b0, host_wr_addr} >= {1'b0, PAY_LO}) && ({1'b0, host_wr_addr} < PAY_HI);
  assign w_reg    = host_wr_en && (host_wr_addr < PAY_LO);
  assign w32      = w_reg && (host_wr_size == SZ_WORD);
  assign w64      = w_reg && (host_wr_size == SZ_DWORD);

  assign cap_we      = w32 && (host_wr_addr == ADDR_W'(OFS_CAP));
  assign ctrl_we     = w32 && (host_wr_addr == ADDR_W'(OFS_CTRL)) && !busy;
  assign cmd_we      = w64 && (host_wr_addr == ADDR_W'(OFS_CMD)) && !busy;
  assign bgs_we      = w64 && (host_wr_addr == ADDR_W'(OFS_BGS));
  assign host_pay_we = host_wr_en && w_in_pay && !busy;
  assign start       = ctrl_we && host_wr_data[0];

  // ---------------- sequencer ----------------
  mbox_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .busy       (busy),
    .req_valid  (req_valid),
    .exec_go    (exec_go),
    .clr_pulse  (clr_pulse),
    .done_pulse (done)
  );

  assign req_opcode  = cmd_q[7:0];
  assign req_cmd_set = cmd_q[15:8];
  assign req_len     = cmd_q[36:16];

  // ---------------- payload storage ----------------
  logic             pw_en;
  logic [IDX_W-1:0] pw_idx;
  logic [7:0]       pw_strb;
  logic [63:0]      pw_data;
  logic [IDX_W-1:0] r_idx;
  logic [63:0]      pay_rd;

  always_comb begin
    if (exec_go) begin
      pw_en   = hnd_wr_en;
      pw_idx  = hnd_wr_idx;
      pw_strb = hnd_wr_strb;
      pw_data = hnd_wr_data;
    end else begin
      pw_en   = host_pay_we;
      pw_idx  = w_off[PAYLOAD_EXP-1:3];
      pw_strb = lane_mask(host_wr_size, w_off[2:0]);
      pw_data = host_wr_data << {w_off[2:0], 3'b000};
    end
  end

  mbox_payload #(.IDX_W(IDX_W)) u_pay (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_pulse),
    .wr_en    (pw_en),
    .wr_idx   (pw_idx),
    .wr_strb  (pw_strb),
    .wr_data  (pw_data),
    .rda_idx  (r_idx),
    .rda_data (pay_rd),
    .rdb_idx  (hnd_rd_idx),
    .rdb_data (hnd_rd_data)
  );

  // ---------------- read path ----------------
  logic [PAYLOAD_EXP-1:0] r_off;
  logic                   r_in_pay, rd8, sts_drop, rd_sts_drop, rd_bg_live;
  logic [63:0]            rd_word, bg_live;

  assign r_off    = PAYLOAD_EXP'(host_rd_addr - PAY_LO);
  assign r_idx    = r_off[PAYLOAD_EXP-1:3];
  assign r_in_pay = ({1'b0, host_rd_addr} >= {1'b0, PAY_LO}) && ({1'b0, host_rd_addr} < PAY_HI);
  assign rd8      = (host_rd_size == SZ_DWORD);
  assign bg_live  = pack_bg(bg_opcode, bg_pct, bg_rc);

  always_comb begin
    rd_word    = 64'd0;
    sts_drop   = 1'b0;
    rd_bg_live = 1'b0;
    if (r_in_pay) begin
      rd_word = pay_rd;
    end else if (host_rd_addr < PAY_LO) begin
      unique case (host_rd_addr[4:3])
        2'd0: rd_word = {ctrl_q, cap_q};
        2'd1: rd_word = cmd_q;
        2'd2: begin
          sts_drop = rd8 && (bg_pct != 7'd0);
          rd_word  = sts_drop ? {sts_q[63:1], 1'b0} : sts_q;
        end
        default: begin
          rd_bg_live = rd8;
          rd_word    = rd8 ? bg_live : bgs_q;
        end
      endcase
    end
  end

  assign rd_sts_drop = host_rd_en && sts_drop;

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q        <= cap_word(5'(PAYLOAD_EXP), 4'(MSI_NUM));
      ctrl_q       <= '0;
      cmd_q        <= '0;
      sts_q        <= '0;
      bgs_q        <= '0;
      host_rd_data <= '0;
    end else begin
      if (cap_we) cap_q <= host_wr_data[31:0];

      if (ctrl_we)   ctrl_q <= host_wr_data[31:0];
      else if (done) ctrl_q <= {ctrl_q[31:1], 1'b0};

      if (cmd_we)    cmd_q <= host_wr_data;
      else if (done) cmd_q <= pack_cmd(cmd_q[15:8], cmd_q[7:0], resp_len);

      if (done)             sts_q <= pack_status(resp_rc, resp_bg);
      else if (rd_sts_drop) sts_q <= {sts_q[63:1], 1'b0};

      if (bgs_we)                        bgs_q <= host_wr_data;
      else if (host_rd_en && rd_bg_live) bgs_q <= bg_live;

      if (host_rd_en) host_rd_data <= narrow(rd_word, r_off[2:0], host_rd_size);
    end
  end

  // ---------------- assertions ----------------
  // R8: doorbell stays set for the whole command
  p_doorbell_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ctrl_q[0]);

  // R8: host cannot disturb the command word mid-command
  p_cmd_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cmd_q));

  // R7: completion drops the doorbell
  p_done_clears_doorbell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ctrl_q[0]);

  // R3: status register ignores host writes
  p_status_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_wr_size == SZ_DWORD && host_wr_addr == ADDR_W'(OFS_STS)
     && !done && !rd_sts_drop) |=> $stable(sts_q));

  // R10: full-width status read with progress drops the background flag
  p_bg_flag_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && rd8 && host_rd_addr == ADDR_W'(OFS_STS) && bg_pct != 7'd0 && !done)
    |=> !sts_q[0]);

  // R5: a doorbell while idle always posts a request
  p_start_posts_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> req_valid);

endmodule

// File: tb/mbox_regs_test.sv
module mbox_regs_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_en;
  logic [11:0] host_wr_addr;
  logic [1:0]  host_wr_size;
  logic [63:0] host_wr_data;
  logic        host_rd_en;
  logic [11:0] host_rd_addr;
  logic [1:0]  host_rd_size;
  logic [63:0] host_rd_data;
  logic        req_valid, req_ready;
  logic [7:0]  req_cmd_set, req_opcode;
  logic [20:0] req_len;
  logic        exec_go, resp_valid, resp_bg;
  logic [15:0] resp_rc;
  logic [20:0] resp_len;
  logic [7:0]  hnd_rd_idx, hnd_wr_idx;
  logic [63:0] hnd_rd_data, hnd_wr_data;
  logic        hnd_wr_en;
  logic [7:0]  hnd_wr_strb;
  logic [15:0] bg_opcode, bg_rc;
  logic [6:0]  bg_pct;

  always #10 clk = ~clk;  // 50 MHz

  mbox_regs uut (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_size(host_wr_size),
    .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr), .host_rd_size(host_rd_size),
    .host_rd_data(host_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd_set(req_cmd_set),
    .req_opcode(req_opcode), .req_len(req_len),
    .exec_go(exec_go), .resp_valid(resp_valid), .resp_rc(resp_rc), .resp_bg(resp_bg),
    .resp_len(resp_len),
    .hnd_rd_idx(hnd_rd_idx), .hnd_rd_data(hnd_rd_data),
    .hnd_wr_en(hnd_wr_en), .hnd_wr_idx(hnd_wr_idx), .hnd_wr_strb(hnd_wr_strb),
    .hnd_wr_data(hnd_wr_data),
    .bg_opcode(bg_opcode), .bg_pct(bg_pct), .bg_rc(bg_rc)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // expected layouts restated from the requirements
  function automatic logic [63:0] exp_cmd(input logic [7:0] set, input logic [7:0] op,
                                          input logic [20:0] len);
    return (64'(len) << 16) | (64'(set) << 8) | 64'(op);
  endfunction

  function automatic logic [63:0] exp_sts(input logic [15:0] rc, input logic bg);
    return (64'(rc) << 32) | 64'(bg);
  endfunction

  localparam int NV = 12;
  localparam logic [11:0] T_WA [NV] = '{12'h020, 12'h029, 12'h02A, 12'h02C, 12'h008, 12'h010,
                                        12'h008, 12'h000, 12'h000, 12'h000, 12'h00C, 12'h004};
  localparam logic [1:0]  T_WS [NV] = '{2'd3, 2'd0, 2'd1, 2'd2, 2'd3, 2'd3,
                                        2'd2, 2'd3, 2'd2, 2'd2, 2'd2, 2'd0};
  localparam logic [63:0] T_WD [NV] = '{64'h1122_3344_5566_7788, // R4 full word
                                        64'h0000_0000_0000_00AB, // R4 single byte
                                        64'h0000_0000_0000_CDEF, // R4 half word
                                        64'h0000_0000_DEAD_BEEF, // R4 word
                                        64'h0000_0000_0004_0312, // R3 command write
                                        64'hFFFF_FFFF_FFFF_FFFF, // R3 status ignores
                                        64'h0000_0000_FFFF_FFFF, // R2 4-byte to command ignored
                                        64'hFFFF_FFFF_FFFF_FFFF, // R3 8-byte at 0x00 ignored
                                        64'h0000_0000_0000_0ABC, // R2 capability write
                                        64'h0000_0000_0000_04CB, // R2 capability restore
                                        64'h0000_0000_FFFF_FFFF, // R2 4-byte at 0x0C ignored
                                        64'h0000_0000_0000_0001};// R2 1-byte control ignored
  localparam logic [11:0] T_RA [NV] = '{12'h020, 12'h028, 12'h028, 12'h028, 12'h008, 12'h010,
                                        12'h008, 12'h000, 12'h000, 12'h000, 12'h008, 12'h000};
  localparam logic [63:0] T_EX [NV] = '{64'h1122_3344_5566_7788, 64'h0000_0000_0000_AB00,
                                        64'h0000_0000_CDEF_AB00, 64'hDEAD_BEEF_CDEF_AB00,
                                        64'h0000_0000_0004_0312, 64'h0000_0000_0000_0000,
                                        64'h0000_0000_0004_0312, 64'h0000_0000_0000_04CB,
                                        64'h0000_0000_0000_0ABC, 64'h0000_0000_0000_04CB,
                                        64'h0000_0000_0004_0312, 64'h0000_0000_0000_04CB};
  localparam string T_TAG [NV] = '{"R4", "R4", "R4", "R4", "R3", "R3",
                                   "R2", "R3", "R2", "R2", "R2", "R2"};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [1:0] s, input logic [63:0] d);
    host_wr_en = 1'b1; host_wr_addr = a; host_wr_size = s; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, input logic [1:0] s, output logic [63:0] d);
    host_rd_en = 1'b1; host_rd_addr = a; host_rd_size = s;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    rst_n = 1'b0;
    host_wr_en = 0; host_wr_addr = '0; host_wr_size = '0; host_wr_data = '0;
    host_rd_en = 0; host_rd_addr = '0; host_rd_size = '0;
    req_ready = 0; resp_valid = 0; resp_rc = '0; resp_bg = 0; resp_len = '0;
    hnd_rd_idx = '0; hnd_wr_en = 0; hnd_wr_idx = '0; hnd_wr_strb = '0; hnd_wr_data = '0;
    bg_opcode = '0; bg_pct = '0; bg_rc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    hread(12'h000, 2'd3, d); check("R1 capability/control", d, 64'h0000_0000_0000_04CB);
    hread(12'h008, 2'd3, d); check("R1 command", d, 64'd0);
    hread(12'h010, 2'd3, d); check("R1 status", d, 64'd0);
    check("R1 no request", {63'd0, req_valid}, 64'd0);

    // vector table: write then full-width readback
    for (int i = 0; i < NV; i++) begin
      hwrite(T_WA[i], T_WS[i], T_WD[i]);
      hread(T_RA[i], 2'd3, d);
      check(T_TAG[i], d, T_EX[i]);
    end
    check("R2 no doorbell from 1-byte control", {63'd0, req_valid}, 64'd0);

    // R5 doorbell raises a request with decoded fields
    hwrite(12'h004, 2'd2, 64'h1);
    check("R5 req_valid", {63'd0, req_valid}, 64'd1);
    check("R5 fields", {19'd0, req_len, req_cmd_set, req_opcode}, {19'd0, 21'd4, 8'h03, 8'h12});
    hnd_rd_idx = 8'd0; #1;
    check("R5 handler input read", hnd_rd_data, 64'h1122_3344_5566_7788);

    // R8 writes while busy are ignored
    hwrite(12'h008, 2'd3, 64'd0);
    hwrite(12'h020, 2'd0, 64'h55);
    hwrite(12'h004, 2'd2, 64'h0);
    hread(12'h008, 2'd3, d); check("R8 command frozen", d, exp_cmd(8'h03, 8'h12, 21'd4));
    hread(12'h020, 2'd3, d); check("R8 payload frozen", d, 64'h1122_3344_5566_7788);
    hread(12'h000, 2'd3, d); check("R8 doorbell reads 1", d, 64'h0000_0001_0000_04CB);
    check("R5 request held", {63'd0, req_valid}, 64'd1);

    // R6 wipe on acceptance
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    check("R6 exec_go", {63'd0, exec_go}, 64'd1);
    hread(12'h020, 2'd3, d); check("R6 payload word 0 wiped", d, 64'd0);
    hread(12'h028, 2'd3, d); check("R6 payload word 1 wiped", d, 64'd0);

    // R7 handler output and completion
    hnd_wr_en = 1'b1; hnd_wr_idx = 8'd0; hnd_wr_strb = 8'hFF; hnd_wr_data = 64'hCAFE;
    @(negedge clk); hnd_wr_en = 1'b0;
    resp_valid = 1'b1; resp_rc = 16'h0005; resp_bg = 1'b1; resp_len = 21'd8;
    @(negedge clk); resp_valid = 1'b0;
    check("R7 request idle", {62'd0, req_valid, exec_go}, 64'd0);
    hread(12'h010, 2'd3, d); check("R7 status (R10 zero pct keeps flag)", d, exp_sts(16'h5, 1'b1));
    hread(12'h008, 2'd3, d); check("R7 command rewritten", d, exp_cmd(8'h03, 8'h12, 21'd8));
    hread(12'h000, 2'd3, d); check("R7 doorbell cleared", d, 64'h0000_0000_0000_04CB);
    hread(12'h020, 2'd3, d); check("R7 handler output", d, 64'h0000_0000_0000_CAFE);

    // R11 narrow reads
    hread(12'h020, 2'd1, d); check("R11 2-byte read", d, 64'hCAFE);
    hread(12'h021, 2'd0, d); check("R11 1-byte read", d, 64'hCA);
    hread(12'h004, 2'd2, d); check("R11 4-byte control read", d, 64'h0);

    // R9 live background status
    bg_opcode = 16'hBEEF; bg_pct = 7'd50; bg_rc = 16'h0007;
    hread(12'h018, 2'd3, d); check("R9 background status", d, 64'h0000_0007_0032_BEEF);

    // R10 read side effect
    hread(12'h010, 2'd2, d); check("R10 narrow read keeps flag", d, 64'h1);
    hread(12'h010, 2'd3, d); check("R10 flag dropped in data", d, exp_sts(16'h5, 1'b0));
    bg_pct = 7'd0;
    hread(12'h010, 2'd3, d); check("R10 flag dropped in register", d, exp_sts(16'h5, 1'b0));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule